// File: doc/BRIEF.md
# Oscillator Start-up Timer with Status

This block is the digital control for a crystal oscillator enable. Software writes a control word that holds an enable bit and an 8-bit start-up count. When the enable bit goes from 0 to 1, the block counts pulses on a slow-clock tick input. After the programmed number of ticks it declares the oscillator stable. A status register shows the stable flag, so software can poll it. A level interrupt is raised while the flag is set and its bit in an interrupt-enable mask is also set. The mask has its own write-one-to-set and write-one-to-clear addresses and a read-back address. The analog oscillator is not modelled. The `osc_stable` output stands in for its settled output.

The count is in units of eight slow ticks. A count of zero means a single tick. The count is captured when start-up begins. Clearing the enable bit drops the stable flag at once and abandons any count in progress. Setting the enable bit again restarts the full start-up time.

The controller is a three-state machine:
- `ST_OFF`: oscillator disabled.
- `ST_START`: counting start-up ticks.
- `ST_STABLE`: start-up time has elapsed.

Its transitions are:
- `T_ENABLE`: `ST_OFF` to `ST_START`, on the enable rising edge.
- `T_SETTLED`: `ST_START` to `ST_STABLE`, on the tick that reaches the captured target.
- `T_ABORT`: `ST_START` to `ST_OFF`, when enable is low.
- `T_DISABLE`: `ST_STABLE` to `ST_OFF`, when enable is low.

In every state a tick that does not complete the count only advances the counter or is ignored.

Top module: `osc_startup_ctrl`

## Requirements
- R1: After reset, `osc_en`, `osc_stable` and `irq` are 0, and reads of the control word (address 0), the status word (address 1) and the mask (address 4) return 0.
- R2: The control word at address 0 has the enable bit at bit 0 and the start-up count N at bits [15:8]; it reads back as written in those bits and zero elsewhere, and `osc_en` equals its bit 0 from the clock edge that takes the write.
- R3: When enable goes from 0 to 1 with N greater than 0, `osc_stable` stays 0 through the first 8*N-1 slow ticks and becomes 1 at the clock edge that samples the 8*N-th tick.
- R4: With N equal to 0, `osc_stable` becomes 1 at the clock edge that samples the first slow tick after enable.
- R5: Writing the control word with bit 0 clear makes `osc_stable` 0 from the edge that takes the write, whether start-up was running or finished; a later enable needs the full start-up time again.
- R6: Writing the control word with bit 0 set while enable is already 1 neither restarts nor retargets a running count, and leaves a set stable flag set; the new N applies at the next enable.
- R7: Bit 0 of the status word at address 1 equals `osc_stable` and the other bits read 0; writes to address 1 have no effect.
- R8: Writing address 2 sets the mask bits that are 1 in the data; writing address 3 clears the mask bits that are 1 in the data; 0 bits leave the mask unchanged; address 4 reads back the mask (bit 0 is the stable source).
- R9: `irq` is 1 exactly while `osc_stable` and mask bit 0 are both 1, held as a level.
- R10: Slow ticks while enable is 0, or before start-up begins, are not counted; with no tick and no write, `osc_stable` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Word address of write and of read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `wr_addr`, combinational |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| osc_en | output | 1 | Oscillator enable to the analog part |
| osc_stable | output | 1 | Start-up time elapsed |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case is a control rewrite that keeps enable at 1 while start-up is counting. The stable flag must then rise on the originally captured target, not on the new count. Any early or late edge is visible only after tens of ticks. The stimulus starts a long count, rewrites the word with a short count partway through, and probes the flag one tick before and at the original target. A second test disables and re-enables back to back in adjacent cycles, mid-count. It checks that a full fresh start-up follows.

// File: rtl/osc_pkg.sv
package osc_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_START  = 2'd1,
        ST_STABLE = 2'd2
    } osc_state_t;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_STATUS = 3'd1;
    localparam logic [2:0] ADDR_IE_SET = 3'd2;
    localparam logic [2:0] ADDR_IE_CLR = 3'd3;
    localparam logic [2:0] ADDR_IE_RD  = 3'd4;

    localparam int EN_BIT  = 0;
    localparam int CNT_LSB = 8;

endpackage

// File: rtl/osc_regs.sv
module osc_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en_q,
    output logic              start_q,
    output logic [CNT_W-1:0]  count_q
);
    import osc_pkg::*;

    logic ctrl_wr;
    logic en_d;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        en_d    = wr_data[EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            start_q <= 1'b0;
            count_q <= '0;
        end else begin
            start_q <= ctrl_wr && en_d && !en_q;
            if (ctrl_wr) begin
                en_q    <= en_d;
                count_q <= wr_data[CNT_LSB +: CNT_W];
            end
        end
    end

endmodule

// File: rtl/osc_timer.sv
module osc_timer #(
    parameter int CNT_W     = 8,
    parameter int UNIT_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic             start_q,
    input  logic [CNT_W-1:0] count_q,
    input  logic             slow_tick,
    output logic             stable,
    output osc_pkg::osc_state_t state_o
);
    import osc_pkg::*;

    localparam int TMR_W = CNT_W + UNIT_LOG2;

    osc_state_t state_q, state_d;
    logic [TMR_W-1:0] ticks_q, ticks_d;
    logic [TMR_W-1:0] target_q, target_d;
    logic [TMR_W-1:0] ticks_inc;
    logic [TMR_W-1:0] target_new;

    always_comb begin
        ticks_inc = ticks_q + TMR_W'(1);
        if (count_q == '0) begin
            target_new = TMR_W'(1);
        end else begin
            target_new = {count_q, {UNIT_LOG2{1'b0}}};
        end
    end

    // Next-state logic: T_ENABLE, T_SETTLED, T_ABORT, T_DISABLE
    always_comb begin
        state_d  = state_q;
        ticks_d  = ticks_q;
        target_d = target_q;
        unique case (state_q)
            ST_OFF: begin
                ticks_d = '0;
                if (start_q) begin
                    state_d  = ST_START;
                    target_d = target_new;
                end
            end
            ST_START: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                    ticks_d = '0;
                end else if (slow_tick) begin
                    if (ticks_inc == target_q) begin
                        state_d = ST_STABLE;
                    end
                    ticks_d = ticks_inc;
                end
            end
            ST_STABLE: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                    ticks_d = '0;
                end
            end
            default: begin
                state_d = ST_OFF;
                ticks_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            ticks_q  <= '0;
            target_q <= TMR_W'(1);
        end else begin
            state_q  <= state_d;
            ticks_q  <= ticks_d;
            target_q <= target_d;
        end
    end

    always_comb begin
        stable  = (state_q == ST_STABLE) && en_q;
        state_o = state_q;
    end

endmodule

// File: rtl/osc_irq.sv
module osc_irq #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int SRC_N  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SRC_N-1:0]  src,
    output logic [SRC_N-1:0]  mask_q,
    output logic              irq
);
    import osc_pkg::*;

    logic set_wr;
    logic clr_wr;

    always_comb begin
        set_wr = wr_en && (wr_addr == ADDR_W'(ADDR_IE_SET));
        clr_wr = wr_en && (wr_addr == ADDR_W'(ADDR_IE_CLR));
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b0;
            end else if (set_wr && wr_data[i]) begin
                mask_q[i] <= 1'b1;
            end else if (clr_wr && wr_data[i]) begin
                mask_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        irq = |(src & mask_q);
    end

endmodule

// File: rtl/osc_startup_ctrl.sv
module osc_startup_ctrl #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 8,
    parameter int UNIT_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              slow_tick,
    output logic              osc_en,
    output logic              osc_stable,
    output logic              irq
);
    import osc_pkg::*;

    localparam int SRC_N = 1;

    logic             en_q;
    logic             start_q;
    logic [CNT_W-1:0] count_q;
    logic             stable;
    logic [SRC_N-1:0] mask_q;
    osc_state_t       state;

    osc_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_q    (en_q),
        .start_q (start_q),
        .count_q (count_q)
    );

    osc_timer #(
        .CNT_W     (CNT_W),
        .UNIT_LOG2 (UNIT_LOG2)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_q      (en_q),
        .start_q   (start_q),
        .count_q   (count_q),
        .slow_tick (slow_tick),
        .stable    (stable),
        .state_o   (state)
    );

    osc_irq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SRC_N  (SRC_N)
    ) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .src     (stable),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (wr_addr)
            ADDR_W'(ADDR_CTRL): begin
                rd_data[EN_BIT]             = en_q;
                rd_data[CNT_LSB +: CNT_W]   = count_q;
            end
            ADDR_W'(ADDR_STATUS): rd_data[0]         = stable;
            ADDR_W'(ADDR_IE_RD):  rd_data[SRC_N-1:0] = mask_q;
            default:              rd_data            = '0;
        endcase
    end

    always_comb begin
        osc_en     = en_q;
        osc_stable = stable;
    end

    logic unused_state;
    assign unused_state = ^state;

endmodule

// File: rtl/osc_startup_chk.sv
module osc_startup_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              slow_tick,
    input logic              osc_en,
    input logic              osc_stable,
    input logic              irq
);
    logic ctrl_wr;
    logic set_wr;
    logic clr_wr;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(0));
    assign set_wr  = wr_en && (wr_addr == ADDR_W'(2)) && wr_data[0];
    assign clr_wr  = wr_en && (wr_addr == ADDR_W'(3)) && wr_data[0];

    AST_STABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stable |-> osc_en); // R5

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[0]) |=> !osc_stable); // R5

    AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (osc_en == $past(wr_data[0]))); // R2

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stable) |-> $past(slow_tick)); // R3

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_tick && !wr_en) |=> $stable(osc_stable)); // R10

    AST_IRQ_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> osc_stable); // R9

    AST_MASK_SET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> (irq == osc_stable)); // R8

    AST_MASK_CLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !irq); // R8

endmodule

bind osc_startup_ctrl osc_startup_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .slow_tick  (slow_tick),
    .osc_en     (osc_en),
    .osc_stable (osc_stable),
    .irq        (irq)
);

// File: tb/test_osc_startup_ctrl.sv
`timescale 1ns/1ps
module test_osc_startup_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic        slow_tick = 1'b0;
    logic        osc_en;
    logic        osc_stable;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    osc_startup_ctrl i_osc_startup_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .slow_tick  (slow_tick),
        .osc_en     (osc_en),
        .osc_stable (osc_stable),
        .irq        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0; wr_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        wr_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] ctrl(input logic en, input logic [7:0] n);
        return {16'd0, n, 7'd0, en};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 osc_en", {31'd0, osc_en}, 32'd0);
        chk("R1 osc_stable", {31'd0, osc_stable}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(3'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(3'd1, d); chk("R1 status", d, 32'd0);
        rd(3'd4, d); chk("R1 mask", d, 32'd0);
    endtask

    task automatic t_ticks_off_then_start;
        logic [31:0] d;
        ticks(20);
        chk("R10 no stable while off", {31'd0, osc_stable}, 32'd0);
        wr(3'd0, ctrl(1'b1, 8'd1));
        chk("R2 osc_en", {31'd0, osc_en}, 32'd1);
        rd(3'd0, d); chk("R2 ctrl readback", d, 32'h0000_0101);
        ticks(7);
        chk("R10 earlier ticks not counted", {31'd0, osc_stable}, 32'd0);
        ticks(1);
        chk("R3 stable at 8th tick", {31'd0, osc_stable}, 32'd1);
        rd(3'd1, d); chk("R7 status bit", d, 32'd1);
        wr(3'd1, 32'd0);
        rd(3'd1, d); chk("R7 write ignored", d, 32'd1);
        wr(3'd0, ctrl(1'b0, 8'd1));
        chk("R5 stable dropped", {31'd0, osc_stable}, 32'd0);
        rd(3'd1, d); chk("R7 status cleared", d, 32'd0);
    endtask

    task automatic t_count_two;
        wr(3'd0, ctrl(1'b1, 8'd2));
        ticks(15);
        chk("R3 low before 16th tick", {31'd0, osc_stable}, 32'd0);
        ticks(1);
        chk("R3 high at 16th tick", {31'd0, osc_stable}, 32'd1);
        wr(3'd0, ctrl(1'b0, 8'd0));
    endtask

    task automatic t_count_zero;
        wr(3'd0, ctrl(1'b1, 8'd0));
        chk("R4 low before tick", {31'd0, osc_stable}, 32'd0);
        ticks(1);
        chk("R4 high at first tick", {31'd0, osc_stable}, 32'd1);
        wr(3'd0, ctrl(1'b0, 8'd0));
    endtask

    task automatic t_abort_restart;
        wr(3'd0, ctrl(1'b1, 8'd1));
        ticks(5);
        wr(3'd0, ctrl(1'b0, 8'd1));
        chk("R5 still low after abort", {31'd0, osc_stable}, 32'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = ctrl(1'b0, 8'd1);
        @(negedge clk);
        wr_data = ctrl(1'b1, 8'd1);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0;
        ticks(7);
        chk("R5 full restart needed", {31'd0, osc_stable}, 32'd0);
        ticks(1);
        chk("R5 stable after fresh 8", {31'd0, osc_stable}, 32'd1);
        wr(3'd0, ctrl(1'b0, 8'd0));
    endtask

    task automatic t_rewrite_enabled;
        logic [31:0] d;
        wr(3'd0, ctrl(1'b1, 8'd3));
        ticks(10);
        wr(3'd0, ctrl(1'b1, 8'd1));
        rd(3'd0, d); chk("R6 new count reads back", d, 32'h0000_0101);
        ticks(13);
        chk("R6 not retargeted at 23", {31'd0, osc_stable}, 32'd0);
        ticks(1);
        chk("R6 stable at original 24", {31'd0, osc_stable}, 32'd1);
        wr(3'd0, ctrl(1'b1, 8'd5));
        chk("R6 stable kept on rewrite", {31'd0, osc_stable}, 32'd1);
        wr(3'd0, ctrl(1'b0, 8'd0));
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(3'd0, ctrl(1'b1, 8'd0));
        ticks(1);
        chk("R9 irq low while masked", {31'd0, irq}, 32'd0);
        wr(3'd2, 32'd0);
        rd(3'd4, d); chk("R8 zero set no effect", d, 32'd0);
        wr(3'd2, 32'd1);
        rd(3'd4, d); chk("R8 mask set", d, 32'd1);
        chk("R9 irq high", {31'd0, irq}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R9 irq held as level", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'd0);
        rd(3'd4, d); chk("R8 zero clear no effect", d, 32'd1);
        wr(3'd0, ctrl(1'b0, 8'd0));
        chk("R9 irq low when not stable", {31'd0, irq}, 32'd0);
        wr(3'd0, ctrl(1'b1, 8'd0));
        ticks(1);
        chk("R9 irq back with stable", {31'd0, irq}, 32'd1);
        wr(3'd3, 32'd1);
        rd(3'd4, d); chk("R8 mask cleared", d, 32'd0);
        chk("R9 irq low when cleared", {31'd0, irq}, 32'd0);
        wr(3'd0, ctrl(1'b0, 8'd0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ticks_off_then_start();
        t_count_two();
        t_count_zero();
        t_abort_restart();
        t_rewrite_enabled();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule